// File: doc/BRIEF.md
# Multiplexed Serial Receive Silo

This block collects received characters from eight serial lines into one shared, tagged first-in first-out store (the silo). Each line's bit-recovery logic, which sits outside this block, pulses a per-line character-done strobe. The strobe carries the character byte and its framing and parity error flags. The block parks each strobed character in a one-deep holding slot for its line. A scanner then moves the lowest-numbered waiting line into the silo, one entry per clock. Each entry carries the line number, the error flags and an overrun mark.

The host pops the silo one read at a time through a 16-bit receive word. It keeps reading until the valid bit comes back clear. A control register holds a scan enable, a receive interrupt enable, a transmit interrupt enable and an alarm enable. With alarm enable set, the receive interrupt is held back until 16 entries are queued. A line parameter write sets one line's speed code, character length, parity, stop bits and receiver enable. The block stores these settings and presents them per line to the bit-recovery logic.

Top module: `mux_rx_silo`

## Requirements
- R1: After synchronous reset the silo is empty, `rd_word` reads 0, `rx_irq` is 0, `ctl_state` is 0 and every per-line configuration output is 0.
- R2: A control write stores `ctl_wdata` into `ctl_state`. The bits are: bit 0 scan enable, bit 1 receive interrupt enable, bit 2 transmit interrupt enable, bit 3 alarm enable.
- R3: A line parameter write updates only the line named in bits 2:0 of `lpr_wdata`. The fields are: bits 4:3 character length code (0 to 3 for 5 to 8 bits), bit 5 two stop bits, bit 6 parity enable, bit 7 odd parity, bits 11:8 speed code, bit 12 receiver enable.
- R4: A strobe on an enabled line becomes the silo's head entry after the second rising edge that follows the strobe. The receive word is laid out as: bits 7:0 the character, bits 10:8 the line, bit 11 zero, bit 12 parity error, bit 13 framing error, bit 14 overrun, bit 15 valid.
- R5: A strobe is discarded if its line's receiver enable is clear, or if scan enable is clear.
- R6: When several lines hold characters, the scanner enters them one per clock in ascending line number.
- R7: `rd_word` shows the head entry, and `rd_pop` removes it at the clock edge. On an empty silo `rd_word` is 0, and a pop leaves the silo unchanged.
- R8: The silo holds 64 entries. A character that reaches a full silo is dropped. A character lost because a newer one replaced it in its holding slot is also dropped. In both cases the next entry written for that line has its overrun bit set.
- R9: `rx_irq` is high when scan enable and receive interrupt enable are both set and the silo holds at least one entry. With alarm enable set, it needs at least 16 entries instead.
- R10: While scan enable is clear, the silo, the holding slots and the overrun marks are cleared within one clock and held empty.
- R11: A break, meaning a framing error with a zero byte, is stored as a normal entry that keeps its zero data and its framing flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 4 | Control write data |
| ctl_state | output | 4 | Current control register |
| lpr_wr | input | 1 | Line parameter write strobe |
| lpr_wdata | input | 16 | Line parameter write data |
| cfg_rx_en | output | 8 | Receiver enable per line |
| cfg_speed | output | 32 | Speed code per line, 4 bits each |
| cfg_char_len | output | 16 | Character length code per line, 2 bits each |
| cfg_par_en | output | 8 | Parity enable per line |
| cfg_par_odd | output | 8 | Odd parity select per line |
| cfg_stop2 | output | 8 | Two stop bits per line |
| char_done | input | 8 | Character-complete strobe per line |
| char_data | input | 64 | Received byte per line, 8 bits each |
| char_ferr | input | 8 | Framing error per line |
| char_perr | input | 8 | Parity error per line |
| rd_pop | input | 1 | Pop the head entry at this edge |
| rd_word | output | 16 | Head entry as a receive word, or 0 when empty |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
A strobe takes two edges to reach the head of the silo: one to fill the line's holding slot and one for the scanner. A pop, a control write and a parameter write each take effect at the single edge where they are sampled. `rx_irq` and `rd_word` follow the silo state without added delay. The bench drives its inputs on falling edges. A behavioural model, built on a queue and per-line holding arrays, advances on every rising edge. All outputs are compared with that model on the following falling edge. Directed checks sample at the falling edge just after the edge where each result is due.

// File: rtl/mrs_pkg.sv
package mrs_pkg;

    localparam int WORD_W       = 16;
    localparam int LINE_FIELD_W = 3;
    localparam int LPR_W        = 16;

    typedef struct packed {
        logic [7:0]              data;
        logic [LINE_FIELD_W-1:0] line;
        logic                    ferr;
        logic                    perr;
        logic                    ovr;
    } rx_entry_t;

    typedef struct packed {
        logic       rx_en;
        logic [3:0] speed;
        logic [1:0] len;
        logic       par_en;
        logic       par_odd;
        logic       stop2;
    } line_cfg_t;

    typedef struct packed {
        logic alarm_en;
        logic tx_ie;
        logic rx_ie;
        logic scan_en;
    } ctl_t;

    function automatic logic [WORD_W-1:0] pack_word(rx_entry_t e, logic v);
        return {v, e.ovr, e.ferr, e.perr, 1'b0, e.line, e.data};
    endfunction

    function automatic line_cfg_t decode_lpr(logic [LPR_W-1:0] w);
        line_cfg_t c;
        c.rx_en   = w[12];
        c.speed   = w[11:8];
        c.par_odd = w[7];
        c.par_en  = w[6];
        c.stop2   = w[5];
        c.len     = w[4:3];
        return c;
    endfunction

endpackage

// File: rtl/mrs_line_regs.sv
module mrs_line_regs
    import mrs_pkg::*;
#(
    parameter int NUM_LINES = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr,
    input  logic [LPR_W-1:0]      wdata,
    output line_cfg_t [NUM_LINES-1:0] cfg
);
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) begin
                cfg[i] <= '0;
            end else if (wr && (wdata[LINE_FIELD_W-1:0] == LINE_FIELD_W'(i))) begin
                cfg[i] <= decode_lpr(wdata);
            end
        end
    end
endmodule

// File: rtl/mrs_capture.sv
module mrs_capture
    import mrs_pkg::*;
#(
    parameter int NUM_LINES = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       scan_en_i,
    input  logic [NUM_LINES-1:0]       rx_en_i,
    input  logic [NUM_LINES-1:0]       done_i,
    input  logic [NUM_LINES-1:0][7:0]  data_i,
    input  logic [NUM_LINES-1:0]       ferr_i,
    input  logic [NUM_LINES-1:0]       perr_i,
    input  logic                       full_i,
    output logic                       push_o,
    output rx_entry_t                  entry_o
);
    logic [NUM_LINES-1:0]      pend_q, ovr_q, ferr_q, perr_q;
    logic [NUM_LINES-1:0][7:0] data_q;
    logic [NUM_LINES-1:0]      grant;
    logic [LINE_FIELD_W-1:0]   gidx;
    logic                      found;

    // lowest-numbered waiting line wins
    always_comb begin
        grant = '0;
        gidx  = '0;
        found = 1'b0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (pend_q[i] && !found) begin
                grant[i] = 1'b1;
                gidx     = LINE_FIELD_W'(i);
                found    = 1'b1;
            end
        end
    end

    assign push_o        = scan_en_i && found && !full_i;
    assign entry_o.data  = data_q[gidx];
    assign entry_o.line  = gidx;
    assign entry_o.ferr  = ferr_q[gidx];
    assign entry_o.perr  = perr_q[gidx];
    assign entry_o.ovr   = ovr_q[gidx];

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_slot
        logic take, lost;
        assign take = done_i[i] && rx_en_i[i];
        assign lost = (take && pend_q[i] && !grant[i]) || (grant[i] && full_i);

        always_ff @(posedge clk) begin
            if (rst || !scan_en_i) begin
                pend_q[i] <= 1'b0;
                ovr_q[i]  <= 1'b0;
                data_q[i] <= '0;
                ferr_q[i] <= 1'b0;
                perr_q[i] <= 1'b0;
            end else begin
                pend_q[i] <= take || (pend_q[i] && !grant[i]);
                ovr_q[i]  <= (ovr_q[i] && !(grant[i] && !full_i)) || lost;
                if (take) begin
                    data_q[i] <= data_i[i];
                    ferr_q[i] <= ferr_i[i];
                    perr_q[i] <= perr_i[i];
                end
            end
        end

        a_r5_disabled_line_ignored: assert property (@(posedge clk) disable iff (rst)
            (!rx_en_i[i] && !pend_q[i]) |=> !pend_q[i]);

        a_r8_drop_marks_overrun: assert property (@(posedge clk) disable iff (rst)
            (scan_en_i && grant[i] && full_i) |=> ovr_q[i]);
    end
endmodule

// File: rtl/mrs_silo.sv
module mrs_silo
    import mrs_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             push,
    input  rx_entry_t        push_entry,
    input  logic             pop,
    output rx_entry_t        head,
    output logic [CNT_W-1:0] count,
    output logic             empty,
    output logic             full
);
    rx_entry_t        mem [DEPTH];
    logic [PTR_W-1:0] rd_ptr, wr_ptr;
    logic             do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CNT_W'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push && !rst && !clear) mem[wr_ptr] <= push_entry;
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

    a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));

    a_r7_empty_pop_no_change: assert property (@(posedge clk) disable iff (rst)
        (!clear && pop && !push && empty) |=> empty);
endmodule

// File: rtl/mux_rx_silo.sv
module mux_rx_silo
    import mrs_pkg::*;
#(
    parameter int NUM_LINES   = 8,
    parameter int DEPTH       = 64,
    parameter int ALARM_LEVEL = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   ctl_wr,
    input  logic [3:0]             ctl_wdata,
    output logic [3:0]             ctl_state,
    input  logic                   lpr_wr,
    input  logic [15:0]            lpr_wdata,
    output logic [NUM_LINES-1:0]   cfg_rx_en,
    output logic [4*NUM_LINES-1:0] cfg_speed,
    output logic [2*NUM_LINES-1:0] cfg_char_len,
    output logic [NUM_LINES-1:0]   cfg_par_en,
    output logic [NUM_LINES-1:0]   cfg_par_odd,
    output logic [NUM_LINES-1:0]   cfg_stop2,
    input  logic [NUM_LINES-1:0]   char_done,
    input  logic [8*NUM_LINES-1:0] char_data,
    input  logic [NUM_LINES-1:0]   char_ferr,
    input  logic [NUM_LINES-1:0]   char_perr,
    input  logic                   rd_pop,
    output logic [15:0]            rd_word,
    output logic                   rx_irq
);
    ctl_t                      ctl_q;
    line_cfg_t [NUM_LINES-1:0] cfg;
    logic [NUM_LINES-1:0][7:0] data_arr;
    logic                      push, full, empty;
    rx_entry_t                 push_entry, head;
    logic [CNT_W-1:0]          count;

    always_ff @(posedge clk) begin
        if (rst)         ctl_q <= '0;
        else if (ctl_wr) ctl_q <= ctl_t'(ctl_wdata);
    end
    assign ctl_state = ctl_q;

    mrs_line_regs #(.NUM_LINES(NUM_LINES)) u_regs (
        .clk(clk), .rst(rst), .wr(lpr_wr), .wdata(lpr_wdata), .cfg(cfg)
    );

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_map
        assign cfg_rx_en[i]          = cfg[i].rx_en;
        assign cfg_speed[4*i +: 4]   = cfg[i].speed;
        assign cfg_char_len[2*i +: 2] = cfg[i].len;
        assign cfg_par_en[i]         = cfg[i].par_en;
        assign cfg_par_odd[i]        = cfg[i].par_odd;
        assign cfg_stop2[i]          = cfg[i].stop2;
        assign data_arr[i]           = char_data[8*i +: 8];
    end

    mrs_capture #(.NUM_LINES(NUM_LINES)) u_cap (
        .clk(clk), .rst(rst), .scan_en_i(ctl_q.scan_en), .rx_en_i(cfg_rx_en),
        .done_i(char_done), .data_i(data_arr), .ferr_i(char_ferr), .perr_i(char_perr),
        .full_i(full), .push_o(push), .entry_o(push_entry)
    );

    mrs_silo #(.DEPTH(DEPTH)) u_silo (
        .clk(clk), .rst(rst), .clear(!ctl_q.scan_en), .push(push), .push_entry(push_entry),
        .pop(rd_pop), .head(head), .count(count), .empty(empty), .full(full)
    );

    assign rd_word = empty ? '0 : pack_word(head, 1'b1);
    assign rx_irq  = ctl_q.scan_en && ctl_q.rx_ie &&
                     (ctl_q.alarm_en ? (count >= CNT_W'(ALARM_LEVEL)) : !empty);

    a_r9_irq_needs_entry: assert property (@(posedge clk) disable iff (rst)
        rx_irq |-> rd_word[15]);

    a_r10_flush_when_idle: assert property (@(posedge clk) disable iff (rst)
        !ctl_q.scan_en |=> (rd_word == '0));

    a_r4_valid_word_shape: assert property (@(posedge clk) disable iff (rst)
        rd_word[15] |-> !rd_word[11]);
endmodule

// File: tb/mux_rx_silo_test.sv
module mux_rx_silo_test;
    localparam int NL = 8;
    localparam int DEPTH = 64;
    localparam int ALARM = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ctl_wr = 1'b0;
    logic [3:0] ctl_wdata = '0;
    logic [3:0] ctl_state;
    logic lpr_wr = 1'b0;
    logic [15:0] lpr_wdata = '0;
    logic [NL-1:0] cfg_rx_en, cfg_par_en, cfg_par_odd, cfg_stop2;
    logic [4*NL-1:0] cfg_speed;
    logic [2*NL-1:0] cfg_char_len;
    logic [NL-1:0] char_done = '0, char_ferr = '0, char_perr = '0;
    logic [8*NL-1:0] char_data = '0;
    logic rd_pop = 1'b0;
    logic [15:0] rd_word;
    logic rx_irq;

    int vectors = 0;
    int errors = 0;
    bit cmp_on = 1'b0;

    always #10 clk = ~clk;

    mux_rx_silo uut (
        .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_state(ctl_state),
        .lpr_wr(lpr_wr), .lpr_wdata(lpr_wdata), .cfg_rx_en(cfg_rx_en), .cfg_speed(cfg_speed),
        .cfg_char_len(cfg_char_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_stop2(cfg_stop2), .char_done(char_done), .char_data(char_data),
        .char_ferr(char_ferr), .char_perr(char_perr), .rd_pop(rd_pop), .rd_word(rd_word),
        .rx_irq(rx_irq)
    );

    // behavioural reference model
    logic [15:0] m_q[$];
    logic [3:0]  m_ctl;
    bit          m_pend[NL], m_ovr[NL], m_pf[NL], m_pp[NL];
    logic [7:0]  m_pdata[NL];
    bit          m_rxen[NL], m_pe[NL], m_po[NL], m_s2[NL];
    logic [3:0]  m_speed[NL];
    logic [1:0]  m_len[NL];

    always @(posedge clk) begin
        if (rst) begin
            m_q.delete();
            m_ctl = '0;
            for (int i = 0; i < NL; i++) begin
                m_pend[i] = 0; m_ovr[i] = 0; m_pf[i] = 0; m_pp[i] = 0; m_pdata[i] = '0;
                m_rxen[i] = 0; m_pe[i] = 0; m_po[i] = 0; m_s2[i] = 0;
                m_speed[i] = '0; m_len[i] = '0;
            end
        end else begin
            if (!m_ctl[0]) begin
                m_q.delete();
                for (int i = 0; i < NL; i++) begin m_pend[i] = 0; m_ovr[i] = 0; end
            end else begin
                automatic int sz = m_q.size();
                automatic bit full = (sz == DEPTH);
                automatic int g = -1;
                for (int i = 0; i < NL; i++) if (m_pend[i] && g < 0) g = i;
                if (rd_pop && sz > 0) void'(m_q.pop_front());
                if (g >= 0) begin
                    if (!full) begin
                        m_q.push_back({1'b1, m_ovr[g], m_pf[g], m_pp[g], 1'b0, 3'(g), m_pdata[g]});
                        m_ovr[g] = 0;
                    end else begin
                        m_ovr[g] = 1;
                    end
                    m_pend[g] = 0;
                end
                for (int i = 0; i < NL; i++) begin
                    if (char_done[i] && m_rxen[i]) begin
                        if (m_pend[i]) m_ovr[i] = 1;
                        m_pend[i] = 1;
                        m_pdata[i] = char_data[8*i +: 8];
                        m_pf[i] = char_ferr[i];
                        m_pp[i] = char_perr[i];
                    end
                end
            end
            if (ctl_wr) m_ctl = ctl_wdata;
            if (lpr_wr) begin
                automatic int l = int'(lpr_wdata[2:0]);
                m_rxen[l] = lpr_wdata[12]; m_speed[l] = lpr_wdata[11:8];
                m_po[l] = lpr_wdata[7]; m_pe[l] = lpr_wdata[6];
                m_s2[l] = lpr_wdata[5]; m_len[l] = lpr_wdata[4:3];
            end
        end
    end

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on && !rst) begin
            automatic logic [15:0] ew = (m_q.size() > 0) ? m_q[0] : 16'h0;
            automatic bit ei = m_ctl[0] && m_ctl[1] &&
                               (m_ctl[3] ? (m_q.size() >= ALARM) : (m_q.size() > 0));
            automatic logic [NL-1:0] erx, epe, epo, es2;
            automatic logic [4*NL-1:0] esp;
            automatic logic [2*NL-1:0] eln;
            for (int i = 0; i < NL; i++) begin
                erx[i] = m_rxen[i]; epe[i] = m_pe[i]; epo[i] = m_po[i]; es2[i] = m_s2[i];
                esp[4*i +: 4] = m_speed[i]; eln[2*i +: 2] = m_len[i];
            end
            chk(rd_word === ew, "R7 head word", 32'(rd_word), 32'(ew));
            chk(rx_irq === ei, "R9 interrupt", 32'(rx_irq), 32'(ei));
            chk(ctl_state === m_ctl, "R2 control", 32'(ctl_state), 32'(m_ctl));
            chk({cfg_rx_en, cfg_par_en, cfg_par_odd, cfg_stop2} === {erx, epe, epo, es2},
                "R3 line flags", {cfg_rx_en, cfg_par_en, cfg_par_odd, cfg_stop2},
                {erx, epe, epo, es2});
            chk(cfg_speed === esp, "R3 speed", cfg_speed, esp);
            chk(cfg_char_len === eln, "R3 length", 32'(cfg_char_len), 32'(eln));
        end
    end

    task automatic tick(); @(negedge clk); endtask

    task automatic wr_ctl(logic [3:0] v);
        ctl_wr = 1'b1; ctl_wdata = v; tick(); ctl_wr = 1'b0;
    endtask

    task automatic wr_lpr(logic [15:0] v);
        lpr_wr = 1'b1; lpr_wdata = v; tick(); lpr_wr = 1'b0;
    endtask

    task automatic strobe(logic [NL-1:0] mask, logic [7:0] d, bit fe, bit pe);
        char_done = mask;
        for (int i = 0; i < NL; i++) char_data[8*i +: 8] = d + 8'(i);
        char_ferr = fe ? mask : '0;
        char_perr = pe ? mask : '0;
        tick();
        char_done = '0; char_ferr = '0; char_perr = '0;
    endtask

    task automatic pop();
        rd_pop = 1'b1; tick(); rd_pop = 1'b0;
    endtask

    initial begin
        #4_000_000;
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        tick(); tick(); tick();
        // R1 reset state
        chk(rd_word === 16'h0 && rx_irq === 1'b0 && ctl_state === 4'h0, "R1 reset outputs",
            {rd_word, 12'h0, ctl_state}, 32'h0);
        chk(cfg_rx_en === '0 && cfg_speed === '0, "R1 reset cfg", cfg_speed, 32'h0);
        rst = 1'b0;
        cmp_on = 1'b1;
        tick();

        // R2: scan + rx irq enable
        wr_ctl(4'b0011);
        chk(ctl_state === 4'b0011, "R2 ctl write", 32'(ctl_state), 32'h3);

        // R3: configure all lines, varied fields, all receivers enabled
        for (int i = 0; i < NL; i++)
            wr_lpr(16'h1000 | (16'(i) << 8) | (16'(i & 3) << 3) | (16'(i & 7) << 5) | 16'(i));
        wr_lpr(16'h1BF3); // line 3: speed B, odd, par, stop2, len 2
        chk(cfg_speed[15:12] === 4'hB && cfg_char_len[7:6] === 2'd2 && cfg_par_odd[3]
            && cfg_par_en[3] && cfg_stop2[3] && cfg_rx_en[3], "R3 line 3 fields",
            {cfg_speed[15:12], cfg_char_len[7:6]}, 32'h2e);
        chk(cfg_speed[19:16] === 4'h4, "R3 other line untouched", 32'(cfg_speed[19:16]), 32'h4);

        // R4: single character, line 3
        strobe(8'h08, 8'h57, 0, 0); // line 3 data 0x57+3 = 0x5A
        chk(rd_word === 16'h0, "R4 not yet after one edge", 32'(rd_word), 32'h0);
        tick();
        chk(rd_word === 16'h835A, "R4 word layout", 32'(rd_word), 32'h835A);
        chk(rx_irq === 1'b1, "R9 per-character irq", 32'(rx_irq), 32'h1);
        pop();
        // R7 empty read, pop on empty
        chk(rd_word === 16'h0 && rx_irq === 1'b0, "R7 empty read", 32'(rd_word), 32'h0);
        pop();
        chk(rd_word === 16'h0, "R7 pop on empty", 32'(rd_word), 32'h0);

        // R5: line 5 receiver disabled
        wr_lpr(16'h0005);
        strobe(8'h20, 8'h10, 0, 0);
        tick(); tick();
        chk(rd_word === 16'h0, "R5 disabled line dropped", 32'(rd_word), 32'h0);
        wr_lpr(16'h1005);

        // R6: lines 7, 2, 0 at once; expect 0, 2, 7
        strobe(8'h85, 8'h40, 0, 0);
        tick(); tick(); tick();
        chk(rd_word === 16'h8040, "R6 first line 0", 32'(rd_word), 32'h8040);
        pop();
        chk(rd_word === 16'h8242, "R6 then line 2", 32'(rd_word), 32'h8242);
        pop();
        chk(rd_word === 16'h8747, "R6 then line 7", 32'(rd_word), 32'h8747);
        pop();

        // R11: break on line 1 (data 0, framing), parity on line 6
        strobe(8'h02, 8'hFF, 1, 0); // 0xFF + 1 = 0x00
        tick();
        chk(rd_word === 16'hA100, "R11 break entry", 32'(rd_word), 32'hA100);
        pop();
        strobe(8'h40, 8'h0A, 0, 1);
        tick();
        chk(rd_word === 16'h9610, "R4 parity flag", 32'(rd_word), 32'h9610);
        pop();

        // R9 alarm mode and R8 fill to capacity
        wr_ctl(4'b1011);
        for (int k = 0; k < DEPTH; k++) begin
            strobe(8'h01, 8'(k), 0, 0);
            if (k == ALARM - 1)
                chk(rx_irq === 1'b0, "R9 alarm below level", 32'(rx_irq), 32'h0);
            if (k == ALARM)
                chk(rx_irq === 1'b1, "R9 alarm at level", 32'(rx_irq), 32'h1);
        end
        tick();
        strobe(8'h10, 8'hA6, 0, 0); // line 4 0xAA, dropped at full
        tick();
        chk(rd_word === 16'h8000, "R8 head unchanged when full", 32'(rd_word), 32'h8000);
        pop();
        strobe(8'h10, 8'hB7, 0, 0); // line 4 0xBB
        tick();
        for (int k = 1; k < DEPTH; k++) pop();
        chk(rd_word === 16'hC4BB, "R8 overrun marked", 32'(rd_word), 32'hC4BB);
        pop();
        chk(rd_word === 16'h0, "R7 drained", 32'(rd_word), 32'h0);

        // R8 overwrite in holding slot: line 2 strobed twice while line 0 holds the scanner
        wr_ctl(4'b0011);
        strobe(8'h05, 8'h00, 0, 0);
        strobe(8'h04, 8'h10, 0, 0);
        tick(); tick();
        pop();
        chk(rd_word === 16'hC212, "R8 holding overwrite", 32'(rd_word), 32'hC212);
        pop();

        // R10 scan disable flushes and holds empty
        strobe(8'h01, 8'h33, 0, 0);
        tick();
        wr_ctl(4'b0010);
        tick();
        chk(rd_word === 16'h0 && rx_irq === 1'b0, "R10 flushed", 32'(rd_word), 32'h0);
        strobe(8'hFF, 8'h20, 0, 0);
        tick(); tick();
        chk(rd_word === 16'h0, "R5 strobes ignored while scan off", 32'(rd_word), 32'h0);
        wr_ctl(4'b0011);
        tick(); tick();
        chk(rd_word === 16'h0 && rx_irq === 1'b0, "R10 stays empty", 32'(rd_word), 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule